// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block arbitrates interrupt requests for a small processor core. Each source line is one of two kinds, chosen per source by a parameter. An event source sets a sticky pending flag when its input is high, and the flag stays set until the request is serviced or software clears it. A level source has no flag and requests service only while its input is held high. A request competes only when its own enable bit and the global enable are both set. Among the competing requests, the lowest source index wins. The block then gives the core a one-cycle take strobe together with the winning index as a vector number.

Accepting a request clears the global enable, so the running handler is not interrupted unless software sets the global enable again, which allows nesting. A return-from-interrupt sets the global enable again. After a return, the block holds off every request until the core reports that one more instruction has completed. A global-disable command blocks acceptance in the cycle in which it is given. Software writes the enable register through a small write port, and it clears flags by writing ones to them.

Top module: `intc_top`

## Requirements
- R1: After a synchronous reset, `gie_o` is 0, every flag is 0, every enable is 0 and `take_o` is 0.
- R2: For an event source (its `LEVEL_MASK` bit is 0), a high `src_i` bit sets that source's flag at the next clock edge. This happens whatever the state of the source's enable and of the global enable. The flag stays set until it is serviced or cleared.
- R3: A write with `reg_wr_i`=1 and `reg_sel_i`=1 clears each flag whose `reg_wdata_i` bit is 1. Zero bits leave their flags unchanged. If a source's flag is set and cleared in the same cycle, the flag ends up set.
- R4: A level source (its `LEVEL_MASK` bit is 1) never shows a flag. It requests service only in the cycles in which its input is high, so a condition that goes away before it is enabled is never taken.
- R5: When `gie_o` is 1 and at least one enabled request is pending, and nothing blocks acceptance, `take_o` is 1 for exactly one cycle after the next edge. In that cycle `vec_o` holds the index of the winning source. If that source is an event source, its flag is cleared at the same edge.
- R6: Acceptance clears `gie_o` at the same edge that raises `take_o`, so no further request is taken until the global enable is set again. If `gie_set_i` is given in the cycle of acceptance, acceptance still wins.
- R7: Setting the global enable with `gie_set_i` while a handler is running lets an enabled request be taken before any return.
- R8: `reti_i` sets `gie_o`. No request is taken in the return cycle, nor in any later cycle before the first cycle in which `instr_done_i` is 1 strictly after the return. A take can occur in the cycle after that one at the earliest.
- R9: `gie_clr_i` clears `gie_o` and blocks acceptance in its own cycle, even for a request that is raised in that same cycle. If `gie_set_i` and `gie_clr_i` are both given in one cycle, the clear wins.
- R10: When several enabled requests are pending, they are taken one per acceptance in ascending index order (index 0 highest priority). The global enable must be restored between acceptances.
- R11: A write with `reg_wr_i`=1 and `reg_sel_i`=0 loads the enable register from `reg_wdata_i`. Bit i enables source i from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Source request lines, one per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 loads the enables, 1 clears flags by writing ones |
| reg_wdata_i | input | N_SRC | Write data |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable at once |
| reti_i | input | 1 | Core executes a return-from-interrupt |
| instr_done_i | input | 1 | Core completed one instruction |
| take_o | output | 1 | One-cycle strobe: a request was accepted |
| vec_o | output | VEC_W | Index of the accepted source, valid while take_o is 1 |
| gie_o | output | 1 | Current global enable |
| flag_o | output | N_SRC | Pending event flags |
| enable_o | output | N_SRC | Per-source enable register |

## Verification
The hardest situation to reach is a lower-priority flag that is still waiting at a return-from-interrupt, which must then sit out the grace period. The stimulus reaches it by raising two event sources together while the global enable is clear. It then sets the global enable so that the higher-priority source is taken, issues a return, and holds `instr_done_i` low before pulsing it. The bench checks that the waiting source is taken only in the cycle after the pulse. A second case gives the return and the completion pulse in the same cycle, and checks that the pulse does not shorten the grace period. A level request is raised in the same cycle as a global disable to show that it is not taken.

// File: rtl/intc_pkg.sv
package intc_pkg;

    // Largest source count the controller is meant to serve.
    localparam int unsigned INTC_MAX_SRC = 32;

    // Target of a register write.
    typedef enum logic {
        WSEL_ENABLE  = 1'b0,
        WSEL_FLAGCLR = 1'b1
    } wsel_e;

    // Commands that steer the global enable and the grace period.
    typedef struct packed {
        logic set;
        logic clr;
        logic reti;
        logic done;
    } gie_cmd_t;

    // Width of a vector index for n sources.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank
    import intc_pkg::*;
#(
    parameter int unsigned       N_SRC      = 8,
    parameter logic [N_SRC-1:0]  LEVEL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_i,
    input  logic             wr_i,
    input  wsel_e            wsel_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic [N_SRC-1:0] ack_mask_i,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] enable_o,
    output logic [N_SRC-1:0] req_o
);

    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] w1c_mask;

    assign w1c_mask = (wr_i && (wsel_i == WSEL_FLAGCLR)) ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr_i && (wsel_i == WSEL_ENABLE)) begin
            en_q <= wdata_i;
        end
    end

    assign enable_o = en_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (LEVEL_MASK[i]) begin : g_level
            // Level source: no memory, request follows the line.
            assign flag_o[i] = 1'b0;
            assign req_o[i]  = src_i[i] & en_q[i];
        end else begin : g_event
            logic pend_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_q <= 1'b0;
                end else begin
                    // A new event outranks both kinds of clear.
                    pend_q <= src_i[i] | (pend_q & ~w1c_mask[i] & ~ack_mask_i[i]);
                end
            end
            assign flag_o[i] = pend_q;
            assign req_o[i]  = pend_q & en_q[i];

            // An event is never lost, masked or not.
            p_evt_latch_r2: assert property (@(posedge clk) disable iff (rst)
                src_i[i] |=> flag_o[i]);
        end
    end

endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick
    import intc_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned VEC_W = idx_width(N_SRC)
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             any_o,
    output logic [VEC_W-1:0] idx_o
);

    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        // Scan from the top so the lowest set index is left in idx_o.
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = VEC_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_gie_gate.sv
module intc_gie_gate
    import intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gie_cmd_t cmd_i,
    input  logic     take_i,
    output logic     gie_o,
    output logic     allow_o
);

    logic gie_q;
    logic grace_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q <= 1'b0;
        end else if (cmd_i.clr) begin
            gie_q <= 1'b0;
        end else if (take_i) begin
            gie_q <= 1'b0;
        end else if (cmd_i.set || cmd_i.reti) begin
            gie_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grace_q <= 1'b0;
        end else if (cmd_i.reti) begin
            grace_q <= 1'b1;
        end else if (cmd_i.done) begin
            grace_q <= 1'b0;
        end
    end

    assign gie_o   = gie_q;
    assign allow_o = gie_q & ~grace_q & ~cmd_i.clr & ~cmd_i.reti;

    // A clear given together with a set leaves the enable low.
    p_clr_beats_set_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.clr && cmd_i.set) |=> !gie_o);

    // A return always re-arms the global enable unless a clear comes with it.
    p_reti_sets_gie_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.reti && !cmd_i.clr && !take_i) |=> gie_o);

endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int unsigned      N_SRC      = 8,
    parameter logic [N_SRC-1:0] LEVEL_MASK = N_SRC'(8'hC0),
    localparam int unsigned     VEC_W      = idx_width(N_SRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] src_i,
    input  logic             reg_wr_i,
    input  logic             reg_sel_i,
    input  logic [N_SRC-1:0] reg_wdata_i,
    input  logic             gie_set_i,
    input  logic             gie_clr_i,
    input  logic             reti_i,
    input  logic             instr_done_i,
    output logic             take_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             gie_o,
    output logic [N_SRC-1:0] flag_o,
    output logic [N_SRC-1:0] enable_o
);

    logic [N_SRC-1:0] req;
    logic [N_SRC-1:0] ack_mask;
    logic             any_req;
    logic [VEC_W-1:0] pick_idx;
    logic             allow;
    logic             take_now;
    gie_cmd_t         cmd;
    logic             take_q;
    logic [VEC_W-1:0] vec_q;

    assign cmd = '{set: gie_set_i, clr: gie_clr_i, reti: reti_i, done: instr_done_i};

    intc_src_bank #(
        .N_SRC      (N_SRC),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_i),
        .wr_i       (reg_wr_i),
        .wsel_i     (wsel_e'(reg_sel_i)),
        .wdata_i    (reg_wdata_i),
        .ack_mask_i (ack_mask),
        .flag_o     (flag_o),
        .enable_o   (enable_o),
        .req_o      (req)
    );

    intc_prio_pick #(
        .N_SRC (N_SRC)
    ) u_pick (
        .req_i (req),
        .any_o (any_req),
        .idx_o (pick_idx)
    );

    intc_gie_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .take_i  (take_now),
        .gie_o   (gie_o),
        .allow_o (allow)
    );

    assign take_now = allow & any_req;
    assign ack_mask = take_now ? ({{(N_SRC-1){1'b0}}, 1'b1} << pick_idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            take_q <= take_now;
            if (take_now) begin
                vec_q <= pick_idx;
            end
        end
    end

    assign take_o = take_q;
    assign vec_o  = vec_q;

    p_take_single_r5: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o);

    p_take_clears_gie_r6: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !gie_o);

    p_clr_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        gie_clr_i |=> !take_o);

    p_reti_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        reti_i |=> !take_o);

    p_level_flagless_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_o & LEVEL_MASK) == '0);

endmodule

// File: tb/intc_top_tb_top.sv
module intc_top_tb_top;

    localparam int unsigned N     = 8;
    localparam int unsigned VW    = 3;
    localparam int unsigned NROWS = 30;

    typedef struct packed {
        logic [7:0] src;
        logic       wr;
        logic       sel;
        logic [7:0] data;
        logic       set;
        logic       clr;
        logic       reti;
        logic       done;
        logic       x_take;
        logic [2:0] x_vec;
        logic       x_gie;
        logic [7:0] x_flags;
        logic [3:0] req;
    } row_t;

    // Columns: src, wr, sel, data, set, clr, reti, done | take, vec, gie, flags | requirement
    localparam row_t TBL [NROWS] = '{
        '{8'h04,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h04, 4'd2 },  // R2 masked event latched
        '{8'h01,1'b1,1'b0,8'hFF,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h05, 4'd11},  // R11 enables loaded, R2
        '{8'h00,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h05, 4'd6 },  // R6 gie set
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd0,1'b0,8'h04, 4'd5 },  // R5 take src 0
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h04, 4'd6 },  // R6 no second take
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0, 1'b0,3'd0,1'b1,8'h04, 4'd8 },  // R8 return
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h04, 4'd8 },  // R8 grace holds
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd0,1'b1,8'h04, 4'd8 },  // R8 instruction done
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd2,1'b0,8'h00, 4'd10},  // R10 waiting src 2
        '{8'h80,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h00, 4'd4 },  // R4 level, gie off
        '{8'h80,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd7,1'b0,8'h00, 4'd4 },  // R4 level taken
        '{8'h80,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h00, 4'd4 },  // R4 no flag kept
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h00, 4'd4 },  // R4 level gone
        '{8'h40,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h00, 4'd9 },  // R9 same-cycle disable
        '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h08, 4'd2 },  // R2
        '{8'h08,1'b1,1'b1,8'h08,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h08, 4'd3 },  // R3 set beats clear
        '{8'h00,1'b1,1'b1,8'h08,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h00, 4'd3 },  // R3 write one clears
        '{8'h10,1'b1,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h10, 4'd3 },  // R3 zero no effect
        '{8'h00,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h10, 4'd11},  // R11 all disabled
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h10, 4'd2 },  // R2 kept while masked
        '{8'h00,1'b1,1'b0,8'h10,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h10, 4'd11},  // R11 enable next cycle
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd4,1'b0,8'h00, 4'd5 },  // R5 take src 4
        '{8'h02,1'b1,1'b0,8'h12,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h02, 4'd7 },  // R7 set inside handler
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd1,1'b0,8'h00, 4'd7 },  // R7 nested take
        '{8'h12,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b0,8'h12, 4'd10},  // R10 two pending
        '{8'h00,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,1'b1,8'h12, 4'd10},  // R10
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd1,1'b0,8'h10, 4'd10},  // R10 lower index first
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0, 1'b0,3'd0,1'b1,8'h10, 4'd8 },  // R8
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1, 1'b0,3'd0,1'b1,8'h10, 4'd8 },  // R8
        '{8'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b1,3'd4,1'b0,8'h00, 4'd10}   // R10 then src 4
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  src;
    logic          wr, sel;
    logic [N-1:0]  wdata;
    logic          gset, gclr, reti, done;
    logic          take;
    logic [VW-1:0] vec;
    logic          gie;
    logic [N-1:0]  flags, enables;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    intc_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .src_i        (src),
        .reg_wr_i     (wr),
        .reg_sel_i    (sel),
        .reg_wdata_i  (wdata),
        .gie_set_i    (gset),
        .gie_clr_i    (gclr),
        .reti_i       (reti),
        .instr_done_i (done),
        .take_o       (take),
        .vec_o        (vec),
        .gie_o        (gie),
        .flag_o       (flags),
        .enable_o     (enables)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] s, input logic w, input logic sl, input logic [7:0] d,
                         input logic st, input logic cl, input logic rt, input logic dn);
        @(negedge clk);
        src = s; wr = w; sel = sl; wdata = d;
        gset = st; gclr = cl; reti = rt; done = dn;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_state(input string tag, input logic t, input logic [2:0] v,
                                input logic g, input logic [7:0] f);
        chk(tag, "take", int'(take), int'(t));
        if (t) chk(tag, "vec", int'(vec), int'(v));
        chk(tag, "gie", int'(gie), int'(g));
        chk(tag, "flags", int'(flags), int'(f));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                checks++;
                $display("FAIL watchdog (all requirements) actual=hung expected=finished");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1;
        src = '0; wr = 1'b0; sel = 1'b0; wdata = '0;
        gset = 1'b0; gclr = 1'b0; reti = 1'b0; done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "take", int'(take), 0);
        chk("R1", "gie", int'(gie), 0);
        chk("R1", "flags", int'(flags), 0);
        chk("R1", "enables", int'(enables), 0);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NROWS; k++) begin
            string tag;
            tag = $sformatf("R%0d row%0d", TBL[k].req, k);
            drive(TBL[k].src, TBL[k].wr, TBL[k].sel, TBL[k].data,
                  TBL[k].set, TBL[k].clr, TBL[k].reti, TBL[k].done);
            expect_state(tag, TBL[k].x_take, TBL[k].x_vec, TBL[k].x_gie, TBL[k].x_flags);
        end
        chk("R11 table end", "enables", int'(enables), 8'h12);

        // R9: set and clear together, clear wins
        drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
        expect_state("R9 set+clr", 1'b0, 3'd0, 1'b0, 8'h00);

        // R8: a completion in the return cycle does not end the grace period
        drive(8'h01, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_state("R2 pre", 1'b0, 3'd0, 1'b0, 8'h01);
        drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_state("R8 reti+done", 1'b0, 3'd0, 1'b1, 8'h01);
        drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_state("R8 still grace", 1'b0, 3'd0, 1'b1, 8'h01);
        drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_state("R8 done", 1'b0, 3'd0, 1'b1, 8'h01);
        drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_state("R8 take after grace", 1'b1, 3'd0, 1'b0, 8'h00);

        // R6: set given in the acceptance cycle, acceptance wins
        drive(8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_state("R6 arm", 1'b0, 3'd0, 1'b1, 8'h01);
        drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_state("R6 take vs set", 1'b1, 3'd0, 1'b0, 8'h00);

        // R1: reset in mid-run clears everything
        drive(8'h02, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        src = '0; wr = 1'b0; gset = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 mid reset", "gie", int'(gie), 0);
        chk("R1 mid reset", "flags", int'(flags), 0);
        chk("R1 mid reset", "enables", int'(enables), 0);
        chk("R1 mid reset", "take", int'(take), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule